// File: doc/BRIEF.md
# Carry-Preserving Decrement Unit

This execution unit takes an already-fetched operand and subtracts one from it, at an operand size of 8, 16, 32 or 64 bits picked per operation. It returns the wrapped result on a 64-bit bus, ready for write-back. Alongside the result it returns a new arithmetic status word. Carry is copied straight from the incoming status word. Overflow, sign, zero, auxiliary carry and parity are all worked out again from the operand and the result.

Each operation is offered with a single-cycle strobe. The result, the status word and an output strobe appear on the next clock. Back-to-back strobes give one result per clock. The output stage is a two-state machine:
- `OUT_EMPTY` means no result is on offer.
- `OUT_FULL` means a result is on offer.
- Transition *accept*: any state goes to `OUT_FULL` when an input strobe is present.
- Transition *drain*: any state goes to `OUT_EMPTY` when no strobe is present.
- Reset forces `OUT_EMPTY`.

Top module: `decr_unit`

## Requirements
- R1: The low part of `out_result` is `in_operand - 1` at the selected width, wrapping modulo 2^width. Size code 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64.
- R2: For size codes 0, 1 and 2, the bits of `out_result` above the selected width equal the same bits of `in_operand`.
- R3: Overflow (status bit 5) is 1 exactly when the operand at the selected width is the most negative value, a 1 followed by all zeros.
- R4: Sign (status bit 4) equals the top bit of the result at the selected width.
- R5: Zero (status bit 3) is 1 exactly when every result bit at the selected width is 0.
- R6: Auxiliary carry (status bit 2) is 1 exactly when the operand's bits 3..0 are all zero, which is a borrow out of bit 3.
- R7: Parity (status bit 1) is 1 exactly when result bits 7..0 hold an even number of ones.
- R8: Carry (status bit 0) of `out_flags` equals bit 0 of `in_flags` for every operation. Incoming bits 5..1 have no effect on the output.
- R9: The result, the status word and `out_valid` = 1 appear on the clock after `in_valid` = 1. `out_valid` is 0 on the clock after `in_valid` = 0. A low `rst_n` at a clock edge clears `out_valid`, `out_result` and `out_flags` to zero.
- R10: While `in_valid` is 0, `out_result` and `out_flags` keep their last values, whatever `in_operand`, `in_size` and `in_flags` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_operand | input | 64 | Operand to decrement |
| in_size | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bits |
| in_flags | input | 6 | Incoming status word, bit 0 = carry |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Decremented operand for write-back |
| out_flags | output | 6 | {OF, SF, ZF, AF, PF, CF} |

## Verification
The bench builds the unit with its default 64-bit data path and four size lanes, so all four size codes can be reached. Through those codes the bench reaches the wrap from zero to all ones, the overflow case at 0x80, 0x8000, 0x8000_0000 and 0x8000_0000_0000_0000, and the zero result from an operand of one. Nonzero bits above the selected width are used to show that they pass through untouched. A pseudo-random stream with gaps exercises back-to-back operation, the drain transition, holding of the output registers, and carry pass-through against arbitrary incoming status bits.

// File: rtl/decr_pkg.sv
package decr_pkg;

    localparam int unsigned N_LANES = 4;
    localparam int unsigned SZ_W    = $clog2(N_LANES);

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_QUAD = 2'd3
    } op_size_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } status_t;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/decr_lanes.sv
module decr_lanes
    import decr_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] operand,
    input  op_size_e          size,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] lane_mask
);

    logic [DATA_W-1:0] lane_res [N_LANES];
    logic [DATA_W-1:0] lane_msk [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int unsigned LW = 8 << g;
        if (LW < DATA_W) begin : g_part
            assign lane_res[g] = {operand[DATA_W-1:LW], operand[LW-1:0] - LW'(1)};
            assign lane_msk[g] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
        end else begin : g_full
            assign lane_res[g] = operand - DATA_W'(1);
            assign lane_msk[g] = '1;
        end
    end

    always_comb begin
        result    = lane_res[size];
        lane_mask = lane_msk[size];
    end

endmodule

// File: rtl/decr_status.sv
module decr_status
    import decr_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic              carry_in,
    output status_t           status
);

    localparam int unsigned NIB_W = 4;
    localparam int unsigned LOB_W = 8;

    logic [DATA_W-1:0] top_bit;
    logic [DATA_W-1:0] op_lane;
    logic [DATA_W-1:0] res_lane;

    always_comb begin
        top_bit   = lane_mask ^ (lane_mask >> 1);
        op_lane   = operand & lane_mask;
        res_lane  = result & lane_mask;
        status.of = (op_lane == top_bit);
        status.sf = |(res_lane & top_bit);
        status.zf = (res_lane == '0);
        status.af = (operand[NIB_W-1:0] == '0);
        status.pf = ~^result[LOB_W-1:0];
        status.cf = carry_in;
    end

endmodule

// File: rtl/decr_unit.sv
module decr_unit
    import decr_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_operand,
    input  logic [1:0]        in_size,
    input  logic [FLAG_W-1:0] in_flags,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [FLAG_W-1:0] out_flags
);

    out_state_e        st_q, st_d;
    logic [DATA_W-1:0] res_c;
    logic [DATA_W-1:0] mask_c;
    status_t           stat_c;
    logic [DATA_W-1:0] res_q;
    status_t           stat_q;

    decr_lanes #(.DATA_W(DATA_W)) u_lanes (
        .operand   (in_operand),
        .size      (op_size_e'(in_size)),
        .result    (res_c),
        .lane_mask (mask_c)
    );

    decr_status #(.DATA_W(DATA_W)) u_status (
        .operand   (in_operand),
        .result    (res_c),
        .lane_mask (mask_c),
        .carry_in  (in_flags[0]),
        .status    (stat_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OUT_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_EMPTY: st_d = in_valid ? OUT_FULL : OUT_EMPTY;
            OUT_FULL:  st_d = in_valid ? OUT_FULL : OUT_EMPTY;
            default:   st_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            stat_q <= '0;
        end else if (in_valid) begin
            res_q  <= res_c;
            stat_q <= stat_c;
        end
    end

    assign out_valid  = (st_q == OUT_FULL);
    assign out_result = res_q;
    assign out_flags  = stat_q;

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_carry_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_flags[0] == $past(in_flags[0]));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd0 && in_operand[7:0] != 8'h80) |=> !out_flags[5]);
    p_aux_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_flags[2] == ($past(in_operand[3:0]) == 4'h0));
    p_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size != 2'd3) |=> out_result[63:32] == $past(in_operand[63:32]));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_flags)));
    p_ovf_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[5]) |-> !out_flags[4]);

endmodule

// File: tb/tb_decr_unit.sv
module tb_decr_unit;

    typedef struct packed {
        logic [63:0] r;
        logic [5:0]  f;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_size = '0;
    logic [5:0]  in_flags = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t last;
    logic [63:0] lfsr = 64'hACE1_2468_9BDF_1357;

    always #2 clk = ~clk;

    decr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_size(in_size), .in_flags(in_flags), .out_valid(out_valid),
        .out_result(out_result), .out_flags(out_flags)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [63:0] op, input logic [1:0] sz, input logic [5:0] fin);
        exp_t e;
        logic [63:0] lo;
        logic [63:0] msk;
        int w;
        w   = 8 << sz;
        msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        lo  = ((op & msk) + msk) & msk;
        e.r = (op & ~msk) | lo;
        e.f[5] = ((op & msk) == (64'd1 << (w - 1)));
        e.f[4] = lo[w-1];
        e.f[3] = (lo == 64'd0);
        e.f[2] = (op[3:0] == 4'h0);
        e.f[1] = ~^e.r[7:0];
        e.f[0] = fin[0];
        return e;
    endfunction

    function automatic logic [63:0] step(input logic [63:0] v);
        return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
    endfunction

    task automatic send(input logic [63:0] op, input logic [1:0] sz, input logic [5:0] fl);
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        in_size    = sz;
        in_flags   = fl;
        q.push_back(model(op, sz, fl));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            lfsr       = step(lfsr);
            in_operand = lfsr;
            in_size    = lfsr[1:0];
            in_flags   = lfsr[9:4];
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && !done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                last = e;
                chk(out_result == e.r, "R1 result", out_result, e.r);
                chk(out_result[63:8] == e.r[63:8], "R2 upper bits", out_result, e.r);
                chk(out_flags[5] == e.f[5], "R3 overflow", out_flags[5], e.f[5]);
                chk(out_flags[4] == e.f[4], "R4 sign", out_flags[4], e.f[4]);
                chk(out_flags[3] == e.f[3], "R5 zero", out_flags[3], e.f[3]);
                chk(out_flags[2] == e.f[2], "R6 aux carry", out_flags[2], e.f[2]);
                chk(out_flags[1] == e.f[1], "R7 parity", out_flags[1], e.f[1]);
                chk(out_flags[0] == e.f[0], "R8 carry", out_flags[0], e.f[0]);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", q.size(), 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
        chk(out_result == 64'd0 && out_flags == 6'd0, "R9 reset data", out_result, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        #1;
        chk(out_valid == 1'b0, "R9 idle after reset", out_valid, 0);

        // byte corner cases: wrap, overflow, zero, upper bits kept
        send(64'hDEAD_BEEF_CAFE_F000, 2'd0, 6'b111110);
        send(64'h1111_2222_3333_4480, 2'd0, 6'b000001);
        send(64'h0000_0000_0000_0001, 2'd0, 6'b000000);
        send(64'hFFFF_FFFF_FFFF_FF81, 2'd0, 6'b111111);
        idle(1);
        // half word
        send(64'h5555_6666_7777_8000, 2'd1, 6'b000001);
        send(64'hABCD_EF01_2345_0000, 2'd1, 6'b011110);
        send(64'h0000_0000_FFFF_0001, 2'd1, 6'b000000);
        // word
        send(64'h9999_8888_8000_0000, 2'd2, 6'b100000);
        send(64'h7777_6666_0000_0000, 2'd2, 6'b000001);
        send(64'h0000_0001_0000_0001, 2'd2, 6'b000001);
        idle(2);
        // quad
        send(64'h8000_0000_0000_0000, 2'd3, 6'b000000);
        send(64'h0000_0000_0000_0000, 2'd3, 6'b000001);
        send(64'h0000_0000_0000_0001, 2'd3, 6'b111110);
        send(64'h0000_0000_0000_0100, 2'd3, 6'b000000);
        // pseudo-random stream with gaps
        for (int i = 0; i < 200; i++) begin
            lfsr = step(lfsr);
            send(lfsr, lfsr[13:12], lfsr[21:16]);
            if (lfsr[30:28] == 3'd0) idle(1 + lfsr[32]);
        end
        idle(2);
        #1;
        chk(q.size() == 0, "R9 all results returned", q.size(), 0);
        chk(out_valid == 1'b0, "R9 drain", out_valid, 0);
        // R10 hold with changing inputs
        idle(6);
        #1;
        chk(out_result == last.r, "R10 result held", out_result, last.r);
        chk(out_flags == last.f, "R10 flags held", out_flags, last.f);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule